// File: doc/BRIEF.md
# Receive Interface Gain Slicer with Power-Driven Step Control

This block sits at the tail of a receive datapath, just ahead of the 16-bit output quantizer. It takes wide signed I/Q samples and scales them by a power-of-two interface gain. It then saturates and truncates them to 16-bit signed words. The scaling lifts weak narrowband signals so that analog noise, not quantization noise, dominates the output. When negative gain is allowed, it can also pull strong signals down to avoid clipping.

In automatic mode, a power estimator averages I²+Q² over windows of 2^N accepted samples. At the end of each window, a controller moves the left shift one bit (6 dB) toward the largest shift that keeps the scaled average power under a programmable threshold. A host-driven setting can override the automatic choice. That setting may request attenuation of up to three bits, but only when compensation mode is selected. Wideband operation forces unity gain.

Top module: `rx_if_gain_slicer`

## Requirements
- R1: An input sample accepted with `in_valid` high appears on `out_i`/`out_q` one clock later, with `out_valid` high for exactly that cycle. At a shift of 0 the output is floor(x / 2^(IN_W-16)).
- R2: At a shift s in 1..3 the output is floor(x·2^s / 2^(IN_W-16)), saturated to the 16-bit range.
- R3: Any result above +32767 or below -32768 is replaced by that limit and sets `ovf_flag`. `ovf_flag` stays high until a cycle with `ovf_clr` high and no clipping sample.
- R4: The power estimate is the floor of the mean of I²+Q² over 2^`win_log2` accepted samples. Here I and Q are the unity-gain 16-bit views, floor(x / 2^(IN_W-16)). The window restarts whenever the block leaves automatic narrowband mode.
- R5: In automatic narrowband mode, the target shift is the largest k in 1..3 with mean·4^k < `pwr_thresh`, and 0 when no such k exists. The applied shift is never negative.
- R6: The automatic shift changes only after a window completes, by at most one step toward the target. The new value is visible on `gain_shift` within two clocks after the edge that accepts the window's last sample.
- R7: With `nb_mode` low (wideband), `gain_shift` is 0 regardless of the other controls, and the automatic shift is reset to 0.
- R8: With `ext_en` high in narrowband mode, `gain_shift` follows `ext_shift` (3-bit two's complement), where code 3'b100 is treated as -3.
- R9: A negative shift -m is applied only with `comp_mode` high, as floor(x / 2^(IN_W-16+m) + 1/2) (round half up). With `comp_mode` low, a negative external request yields a shift of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | IN_W | Wide signed I sample |
| in_q | input | IN_W | Wide signed Q sample |
| nb_mode | input | 1 | 1 = narrowband, 0 = wideband (unity gain) |
| comp_mode | input | 1 | 1 = compensation mode (attenuation allowed) |
| ext_en | input | 1 | 1 = host setting overrides automatic choice |
| ext_shift | input | 3 | Host shift, signed bits (-3..3) |
| win_log2 | input | WLW | Averaging window exponent N (2^N samples) |
| pwr_thresh | input | 2·OUT_W | Headroom threshold on mean power |
| ovf_clr | input | 1 | Clears the sticky clip flag |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | OUT_W | Saturated signed I output |
| out_q | output | OUT_W | Saturated signed Q output |
| gain_shift | output | 3 | Shift currently applied (signed) |
| ovf_flag | output | 1 | Sticky clip indicator |

## Verification
A wrong power sum or a misplaced window boundary shows up as `gain_shift` stepping one window early or late, or settling on the wrong step. A rounding error shows the same way, for example when a mean of 7 is rounded up to 8 against a threshold of 113. Either fault is visible within two clocks of the window's closing sample. A fault in the scaler datapath appears on `out_i`/`out_q` one clock after the affected sample, as an off-by-one at half-LSB inputs or as a missing clamp at full scale. A broken clip register shows on `ovf_flag` in the same cycle.

// File: rtl/ifg_pkg.sv
package ifg_pkg;
  localparam int unsigned STEP_MAX = 3;
  typedef logic signed [2:0] shift_t;
  typedef logic [1:0]        step_t;
endpackage

// File: rtl/ifg_rssi.sv
module ifg_rssi #(
  parameter int unsigned SW      = 16,
  parameter int unsigned WIN_MAX = 8,
  parameter int unsigned WLW     = 4,
  localparam int unsigned PW     = 2 * SW,
  localparam int unsigned AW     = PW + WIN_MAX
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart,
  input  logic                 smp_valid,
  input  logic signed [SW-1:0] smp_i,
  input  logic signed [SW-1:0] smp_q,
  input  logic [WLW-1:0]       win_log2,
  output logic [PW-1:0]        avg_pwr,
  output logic                 win_done
);
  logic [WIN_MAX-1:0] cnt_q, cnt_d;
  logic [AW-1:0]      acc_q, acc_d, acc_sum;
  logic [PW-1:0]      avg_q, avg_d;
  logic               done_q, done_d;
  logic signed [PW-1:0] sq_i, sq_q;
  logic [PW-1:0]      pwr;
  logic [WLW-1:0]     n_eff;
  logic [WIN_MAX:0]   lim_w;
  logic               last;

  always_comb begin
    sq_i    = smp_i * smp_i;
    sq_q    = smp_q * smp_q;
    pwr     = $unsigned(sq_i) + $unsigned(sq_q);
    n_eff   = (win_log2 > WLW'(WIN_MAX)) ? WLW'(WIN_MAX) : win_log2;
    lim_w   = ({{WIN_MAX{1'b0}}, 1'b1} << n_eff) - 1'b1;
    last    = ({1'b0, cnt_q} >= lim_w);
    acc_sum = acc_q + AW'(pwr);
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    avg_d   = avg_q;
    done_d  = 1'b0;
    if (restart) begin
      cnt_d = '0;
      acc_d = '0;
    end else if (smp_valid) begin
      if (last) begin
        cnt_d  = '0;
        acc_d  = '0;
        avg_d  = PW'(acc_sum >> n_eff);
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
        acc_d = acc_sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      avg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      avg_q  <= avg_d;
      done_q <= done_d;
    end
  end

  assign avg_pwr  = avg_q;
  assign win_done = done_q;
endmodule

// File: rtl/ifg_gain_ctrl.sv
module ifg_gain_ctrl
  import ifg_pkg::*;
#(
  parameter int unsigned PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_done,
  input  logic [PW-1:0] avg_pwr,
  input  logic [PW-1:0] pwr_thresh,
  input  logic          nb_mode,
  input  logic          comp_mode,
  input  logic          ext_en,
  input  shift_t        ext_shift,
  output shift_t        eff_shift
);
  localparam int unsigned XW = PW + 2 * STEP_MAX;

  step_t  auto_q, auto_d, tgt;
  logic   auto_en;
  shift_t ext_c;

  always_comb begin
    tgt = '0;
    for (int k = 1; k <= int'(STEP_MAX); k++) begin
      if ((XW'(avg_pwr) << (2 * k)) < XW'(pwr_thresh)) tgt = step_t'(k);
    end
  end

  always_comb begin
    auto_en = 1'b0;
    auto_d  = auto_q;
    if (!nb_mode) begin
      auto_en = 1'b1;
      auto_d  = '0;
    end else if (win_done && !ext_en) begin
      auto_en = 1'b1;
      if (tgt > auto_q)      auto_d = auto_q + 1'b1;
      else if (tgt < auto_q) auto_d = auto_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       auto_q <= '0;
    else if (auto_en) auto_q <= auto_d;
  end

  always_comb begin
    ext_c = (ext_shift == 3'sb100) ? -3'sd3 : ext_shift;
    if (!nb_mode)    eff_shift = '0;
    else if (ext_en) eff_shift = (ext_c[2] && !comp_mode) ? '0 : ext_c;
    else             eff_shift = shift_t'({1'b0, auto_q});
  end
endmodule

// File: rtl/ifg_scaler.sv
module ifg_scaler
  import ifg_pkg::*;
#(
  parameter int unsigned IN_W  = 24,
  parameter int unsigned OUT_W = 16,
  localparam int unsigned FRAC = IN_W - OUT_W,
  localparam int unsigned EW   = IN_W + 4
) (
  input  logic signed [IN_W-1:0]  x,
  input  shift_t                  shift,
  output logic signed [OUT_W-1:0] y,
  output logic                    clip
);
  logic signed [EW-1:0] xe, t, rnd, hi, lo;
  logic [2:0]           mag;
  int unsigned          r;

  always_comb begin
    xe  = {{(EW-IN_W){x[IN_W-1]}}, x};
    hi  = ({{(EW-1){1'b0}}, 1'b1} <<< (OUT_W - 1)) - 1'b1;
    lo  = -hi - 1'b1;
    mag = 3'(-shift);
    r   = FRAC + 32'(mag);
    rnd = '0;
    if (!shift[2]) begin
      t = (xe <<< shift[1:0]) >>> FRAC;
    end else begin
      rnd = {{(EW-1){1'b0}}, 1'b1} <<< (r - 1);
      t   = (xe + rnd) >>> r;
    end
    clip = 1'b0;
    if (t > hi) begin
      y    = hi[OUT_W-1:0];
      clip = 1'b1;
    end else if (t < lo) begin
      y    = lo[OUT_W-1:0];
      clip = 1'b1;
    end else begin
      y = t[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/rx_if_gain_slicer.sv
module rx_if_gain_slicer
  import ifg_pkg::*;
#(
  parameter int unsigned IN_W    = 24,
  parameter int unsigned OUT_W   = 16,
  parameter int unsigned WIN_MAX = 8,
  localparam int unsigned WLW    = $clog2(WIN_MAX + 1),
  localparam int unsigned PW     = 2 * OUT_W,
  localparam int unsigned FRAC   = IN_W - OUT_W,
  localparam int unsigned NCH    = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_i,
  input  logic signed [IN_W-1:0]  in_q,
  input  logic                    nb_mode,
  input  logic                    comp_mode,
  input  logic                    ext_en,
  input  logic signed [2:0]       ext_shift,
  input  logic [WLW-1:0]          win_log2,
  input  logic [PW-1:0]           pwr_thresh,
  input  logic                    ovf_clr,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_i,
  output logic signed [OUT_W-1:0] out_q,
  output logic signed [2:0]       gain_shift,
  output logic                    ovf_flag
);
  logic signed [IN_W-1:0]  x_arr [NCH];
  logic signed [OUT_W-1:0] y_arr [NCH];
  logic signed [OUT_W-1:0] v_arr [NCH];
  logic [NCH-1:0]          clip_v;
  logic [PW-1:0]           avg_pwr;
  logic                    win_done;
  shift_t                  eff_shift;

  logic                    vld_q, ovf_q, ovf_d;
  logic signed [OUT_W-1:0] oi_q, oq_q;

  assign x_arr[0] = in_i;
  assign x_arr[1] = in_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign v_arr[c] = x_arr[c][IN_W-1:FRAC];
    ifg_scaler #(.IN_W(IN_W), .OUT_W(OUT_W)) u_scl (
      .x(x_arr[c]), .shift(eff_shift), .y(y_arr[c]), .clip(clip_v[c])
    );
  end

  ifg_rssi #(.SW(OUT_W), .WIN_MAX(WIN_MAX), .WLW(WLW)) u_rssi (
    .clk(clk), .rst_n(rst_n), .restart(!nb_mode || ext_en),
    .smp_valid(in_valid), .smp_i(v_arr[0]), .smp_q(v_arr[1]),
    .win_log2(win_log2), .avg_pwr(avg_pwr), .win_done(win_done)
  );

  ifg_gain_ctrl #(.PW(PW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .win_done(win_done), .avg_pwr(avg_pwr),
    .pwr_thresh(pwr_thresh), .nb_mode(nb_mode), .comp_mode(comp_mode),
    .ext_en(ext_en), .ext_shift(ext_shift), .eff_shift(eff_shift)
  );

  always_comb begin
    ovf_d = (ovf_q && !ovf_clr) || (in_valid && (|clip_v));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oi_q <= '0;
      oq_q <= '0;
    end else if (in_valid) begin
      oi_q <= y_arr[0];
      oq_q <= y_arr[1];
    end
  end

  assign out_valid  = vld_q;
  assign out_i      = oi_q;
  assign out_q      = oq_q;
  assign ovf_flag   = ovf_q;
  assign gain_shift = eff_shift;
endmodule

// File: rtl/ifg_checker.sv
module ifg_checker (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              nb_mode,
  input logic              comp_mode,
  input logic              ext_en,
  input logic signed [2:0] ext_shift,
  input logic              ovf_clr,
  input logic              out_valid,
  input logic signed [2:0] gain_shift,
  input logic              ovf_flag
);
  // R1
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R3
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
  // R5
  auto_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nb_mode && !ext_en) |-> !gain_shift[2]);
  // R6
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nb_mode && !ext_en && $past(nb_mode && !ext_en)) |->
      ((gain_shift == $past(gain_shift)) ||
       (gain_shift == $past(gain_shift) + 3'sd1) ||
       (gain_shift == $past(gain_shift) - 3'sd1)));
  // R7
  wb_unity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nb_mode |-> (gain_shift == 3'sd0));
  // R8
  ext_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nb_mode && ext_en && comp_mode && ext_shift != 3'sb100) |-> (gain_shift == ext_shift));
  // R9
  corr_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !comp_mode |-> !gain_shift[2]);
endmodule

bind rx_if_gain_slicer ifg_checker u_ifg_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .nb_mode(nb_mode),
  .comp_mode(comp_mode), .ext_en(ext_en), .ext_shift(ext_shift),
  .ovf_clr(ovf_clr), .out_valid(out_valid), .gain_shift(gain_shift),
  .ovf_flag(ovf_flag)
);

// File: tb/tb_rx_if_gain_slicer.sv
`timescale 1ns/1ps
module tb_rx_if_gain_slicer;
  localparam int IN_W = 24;
  localparam int OUT_W = 16;
  localparam int FR = IN_W - OUT_W;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic signed [IN_W-1:0] in_i, in_q;
  logic nb_mode, comp_mode, ext_en, ovf_clr;
  logic signed [2:0] ext_shift;
  logic [3:0] win_log2;
  logic [31:0] pwr_thresh;
  logic out_valid, ovf_flag;
  logic signed [OUT_W-1:0] out_i, out_q;
  logic signed [2:0] gain_shift;

  int checks = 0;
  int fails = 0;
  int model_auto = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rx_if_gain_slicer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .nb_mode(nb_mode), .comp_mode(comp_mode), .ext_en(ext_en),
    .ext_shift(ext_shift), .win_log2(win_log2), .pwr_thresh(pwr_thresh),
    .ovf_clr(ovf_clr), .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
    .gain_shift(gain_shift), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint mdl(input longint x, input int s);
    longint t;
    if (s >= 0) t = (x * (64'sd1 << s)) >>> FR;
    else begin
      int r = FR - s;
      t = (x + (64'sd1 << (r - 1))) >>> r;
    end
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return t;
  endfunction

  task automatic send(input longint xi, input longint xq);
    @(negedge clk);
    in_valid = 1'b1;
    in_i = IN_W'(xi);
    in_q = IN_W'(xq);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_chk(input string tag, input longint xi, input longint xq, input int s);
    send(xi, xq);
    chk({tag, " out_i"}, out_i, mdl(xi, s));
    chk({tag, " out_q"}, out_q, mdl(xq, s));
  endtask

  // One window of four samples in automatic mode; updates the step model.
  task automatic run_win(input int ai[4], input int aq);
    longint sum = 0;
    longint avg;
    int tgt = 0;
    for (int n = 0; n < 4; n++) begin
      send_chk("R2 auto-scaled", longint'(ai[n]) * 256, longint'(aq) * 256, model_auto);
      sum += longint'(ai[n]) * ai[n] + longint'(aq) * aq;
    end
    avg = sum >>> 2;
    for (int k = 1; k <= 3; k++)
      if (avg * (64'sd1 << (2 * k)) < longint'(pwr_thresh)) tgt = k;
    if (tgt > model_auto) model_auto++;
    else if (tgt < model_auto) model_auto--;
    @(negedge clk);
    @(negedge clk);
    chk("R4 R5 R6 window step", gain_shift, model_auto);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_i = '0; in_q = '0;
    nb_mode = 1'b1; comp_mode = 1'b0; ext_en = 1'b0; ext_shift = '0;
    win_log2 = 4'd2; pwr_thresh = 32'd100_000_000; ovf_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", out_valid, 0);
    chk("R1 reset out_i", out_i, 0);
    chk("R3 reset ovf_flag", ovf_flag, 0);
    chk("R6 reset gain_shift", gain_shift, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 latency: out_valid high exactly one cycle after the strobe
    @(negedge clk);
    in_valid = 1'b1; in_i = 24'sd5000; in_q = -24'sd5000;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 out_valid one cycle", out_valid, 1);
    @(negedge clk);
    chk("R1 out_valid drops", out_valid, 0);

    // R8 R2 R9 sweep of all external shifts in compensation mode
    ext_en = 1'b1; comp_mode = 1'b1;
    for (int s = -3; s <= 3; s++) begin
      @(negedge clk);
      ext_shift = 3'(s);
      #1;
      chk("R8 ext gain_shift", gain_shift, s);
      for (int k = 0; k < 200; k++) begin
        longint x = longint'(k) * 83887 - 8388608 + (k % 5);
        send_chk("R1 R2 R9 sweep", x, -x - 1, s);
      end
      send_chk("R3 full-scale", 8388607, -8388608, s);
      if (s < 0) begin
        longint h = 64'sd1 << (FR - s - 1);
        send_chk("R9 half-up", h, -h, s);
        send_chk("R9 below half", h - 1, -h - 1, s);
      end else begin
        send_chk("R1 R2 lsb edge", 255, -1, s);
      end
    end

    // R3 sticky flag and clear
    chk("R3 sticky after clip", ovf_flag, 1);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    chk("R3 cleared", ovf_flag, 0);
    send_chk("R3 no clip", 1000, -1000, 3);
    chk("R3 stays clear", ovf_flag, 0);
    send_chk("R3 clip pos", 5000000, 0, 3);
    chk("R3 set on clip", ovf_flag, 1);

    // R8 code 3'b100 treated as -3
    @(negedge clk); ext_shift = 3'sb100; #1;
    chk("R8 code 100", gain_shift, -3);

    // R9 correction mode clamps negative request
    @(negedge clk); comp_mode = 1'b0; ext_shift = -3'sd2; #1;
    chk("R9 corr clamp", gain_shift, 0);
    send_chk("R9 corr unity", 1234567, -7654321, 0);

    // R7 wideband forces unity
    @(negedge clk); nb_mode = 1'b0; comp_mode = 1'b1; ext_shift = 3'sd3; #1;
    chk("R7 wb ext", gain_shift, 0);
    send_chk("R7 wb unity", 3000000, -3000000, 0);
    ext_en = 1'b0; comp_mode = 1'b0;
    @(negedge clk);
    nb_mode = 1'b1;
    @(negedge clk);

    // R5 R6 automatic stepping up then down
    model_auto = 0;
    chk("R6 auto start", gain_shift, 0);
    for (int w = 0; w < 4; w++) run_win('{1000, 1000, 1000, 1000}, 0);
    for (int w = 0; w < 3; w++) run_win('{20000, 20000, 20000, 20000}, 0);

    // R4 floor of mean: 30/4 -> 7, threshold 113 -> target 2
    pwr_thresh = 32'd113;
    for (int w = 0; w < 3; w++) run_win('{1, 2, 3, 4}, 0);
    pwr_thresh = 32'd100_000_000;
    run_win('{3000, 3000, 3000, 3000}, 0);
    run_win('{2000, 2000, 2000, 2000}, 1000);

    // R7 wideband resets the automatic step
    for (int w = 0; w < 3; w++) run_win('{100, 100, 100, 100}, 100);
    @(negedge clk); nb_mode = 1'b0;
    @(negedge clk); nb_mode = 1'b1; #1;
    model_auto = 0;
    chk("R7 auto reset", gain_shift, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule